// File: doc/BRIEF.md
# Binary-Field Polynomial Inverter (Extended Euclid)

This block computes the multiplicative inverse of a nonzero polynomial a(x) over GF(2) of degree at most m−1, modulo a fixed irreducible polynomial f(x) of degree m. It runs the Euclidean remainder sequence on (f, a). Each round uses a sequential polynomial divider. The divider removes one leading term of the running remainder per clock, and it shifts the divisor by the current degree difference.

The Bézout coefficient is kept alongside the remainder sequence. After each division with a nonzero remainder, a carry-less multiplier and an XOR update the coefficient pair. The final coefficient is therefore the inverse as soon as a zero remainder appears, and no second pass is needed. A client pulses `start` with the operand and later sees a one-cycle `done`. The result stays on `inv_out` until the next accepted start. A zero operand is outside the contract, and its behaviour is unspecified.

Top module: `gf2m_eea_inverter`

## Requirements
- R1: After reset, `done` is 0 and `inv_out` is all zeros until the first accepted start.
- R2: For every nonzero operand, the `inv_out` value shown with `done` multiplied by the operand and reduced modulo f(x) equals 1 (default m = 8, f = 0x11B, i.e. x^8+x^4+x^3+x+1, bit i holding the coefficient of x^i).
- R3: `done` is high for exactly one cycle per accepted start.
- R4: `start` is sampled only while the block is idle. A `start` during a computation, or in the cycle where `done` is high, changes neither the result nor the timing of that computation, and it does not begin a new one.
- R5: `inv_out` holds the result from the `done` cycle until the next accepted start.
- R6: The operand 1 completes after a single division and returns 1.
- R7: Latency is exact. Let k be the number of nonzero quotient coefficients of a division round. Counting clock edges after the edge that samples `start`, each round whose remainder is nonzero costs k+4 edges and the final round (zero remainder) costs k+3 edges. `done` is high right after the last of these edges.
- R8: The coefficient product g2·q never has a term of degree m or above, so no modular reduction is applied to the coefficient.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Begin an inversion; sampled only while idle |
| a_in | input | M | Operand polynomial, bit i = coefficient of x^i |
| done | output | 1 | One-cycle pulse when the inverse is ready |
| inv_out | output | M | Inverse polynomial, held until the next start |

## Verification
The bench sweeps all 255 nonzero operands. It checks each result by field multiplication, and it predicts the exact edge on which `done` appears by replaying the division rounds itself. A divider that took one cycle per dividend bit instead of per quotient term, or a controller that committed the coefficients on the terminating round, would shift `done` or corrupt the result, and either fault is caught. The operand 1, whose only round terminates at once, exposes a design that always performs at least one coefficient update. Stray starts inside a computation and on the `done` cycle catch a controller that restarts or re-arms while busy.

// File: rtl/gfinv_pkg.sv
// Shared types for the binary-field inverter.
package gfinv_pkg;
    // Controller states: idle/load, divide, commit coefficients, present result.
    typedef enum logic [1:0] {
        ST_IDLE = 2'd0,
        ST_DIV  = 2'd1,
        ST_STEP = 2'd2,
        ST_OUT  = 2'd3
    } inv_state_t;
endpackage

// File: rtl/msb_index.sv
// Leading-one detector: returns the index of the highest set bit of vec
// and whether vec is nonzero. idx is 0 when vec is zero.
module msb_index #(
    parameter int W  = 9,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic [W-1:0]  vec,
    output logic [IW-1:0] idx,
    output logic          nz
);
    // Scan upward so the last set bit found is the highest.
    always_comb begin
        idx = '0;
        nz  = |vec;
        for (int i = 0; i < W; i++) begin
            if (vec[i]) idx = IW'(i);
        end
    end
endmodule

// File: rtl/poly_divider.sv
// Sequential GF(2) polynomial divider. Each cycle it cancels the leading
// term of the running remainder, shifting the divisor by the degree
// difference. One cycle per quotient term. Assumes a nonzero divisor.
// valid pulses for one cycle once rem has degree below the divisor.
module poly_divider #(
    parameter int W  = 9,
    localparam int IW = (W > 1) ? $clog2(W) : 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         go,
    input  logic [W-1:0] dividend,
    input  logic [W-1:0] divisor,
    output logic [W-1:0] quot,
    output logic [W-1:0] rem,
    output logic         valid
);
    logic [W-1:0]  rem_q, quot_q;
    logic          busy_q, valid_q;
    logic [IW-1:0] r_idx, d_idx, shamt;
    logic          r_nz, d_nz;
    logic          can_step;

    msb_index #(.W(W)) u_rdeg (.vec(rem_q),   .idx(r_idx), .nz(r_nz));
    msb_index #(.W(W)) u_ddeg (.vec(divisor), .idx(d_idx), .nz(d_nz));

    // Decide whether another leading term can be cancelled.
    always_comb begin
        shamt    = r_idx - d_idx;
        can_step = r_nz && d_nz && (r_idx >= d_idx);
    end

    // Load, iterate one quotient term per cycle, then flag completion.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rem_q   <= '0;
            quot_q  <= '0;
            busy_q  <= 1'b0;
            valid_q <= 1'b0;
        end else if (go) begin
            rem_q   <= dividend;
            quot_q  <= '0;
            busy_q  <= 1'b1;
            valid_q <= 1'b0;
        end else if (busy_q) begin
            if (can_step) begin
                rem_q  <= rem_q ^ (divisor << shamt);
                quot_q <= quot_q | (W'(1) << shamt);
            end else begin
                busy_q  <= 1'b0;
                valid_q <= 1'b1;
            end
        end else begin
            valid_q <= 1'b0;
        end
    end

    assign quot  = quot_q;
    assign rem   = rem_q;
    assign valid = valid_q;
endmodule

// File: rtl/clmul.sv
// Carry-less (GF(2)) multiplier, purely combinational, no reduction.
module clmul #(
    parameter int AW = 8,
    parameter int BW = 9,
    localparam int PW = AW + BW - 1
) (
    input  logic [AW-1:0] a,
    input  logic [BW-1:0] b,
    output logic [PW-1:0] p
);
    logic [PW-1:0] part [BW];

    for (genvar gi = 0; gi < BW; gi++) begin : g_part
        assign part[gi] = b[gi] ? ({{(BW-1){1'b0}}, a} << gi) : '0;
    end

    // Fold the partial products with XOR.
    always_comb begin
        p = '0;
        for (int i = 0; i < BW; i++) p = p ^ part[i];
    end
endmodule

// File: rtl/gf2m_eea_inverter.sv
// Extended-Euclid inverter over GF(2^M) modulo a fixed irreducible POLY
// (degree M, bit M set). The operand must be nonzero. A four-state
// controller runs the divider repeatedly. The Bezout coefficient is
// updated after every division whose remainder is nonzero, so the
// inverse is ready when a zero remainder appears.
module gf2m_eea_inverter #(
    parameter int         M    = 8,
    parameter logic [M:0] POLY = 9'h11B
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         start,
    input  logic [M-1:0] a_in,
    output logic         done,
    output logic [M-1:0] inv_out
);
    import gfinv_pkg::*;

    localparam int DW = M + 1;
    localparam int PW = 2 * M;

    inv_state_t    state_q;
    logic [DW-1:0] f_q, a_q;
    logic [M-1:0]  g1_q, g2_q;
    logic          launch_q;
    logic [DW-1:0] div_quot, div_rem;
    logic          div_valid;
    logic [PW-1:0] prod;
    logic [M-1:0]  prod_hi;
    logic [M-1:0]  g2_next;

    poly_divider #(.W(DW)) u_div (
        .clk      (clk),
        .rst_n    (rst_n),
        .go       (launch_q),
        .dividend (f_q),
        .divisor  (a_q),
        .quot     (div_quot),
        .rem      (div_rem),
        .valid    (div_valid)
    );

    clmul #(.AW(M), .BW(DW)) u_mul (
        .a (g2_q),
        .b (div_quot),
        .p (prod)
    );

    // Next coefficient: low half of g2*q plus the older coefficient.
    always_comb begin
        prod_hi = prod[PW-1:M];
        g2_next = prod[M-1:0] ^ g1_q;
    end

    // Controller: load, divide, commit the round, present the result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q  <= ST_IDLE;
            f_q      <= '0;
            a_q      <= '0;
            g1_q     <= '0;
            g2_q     <= '0;
            launch_q <= 1'b0;
        end else begin
            launch_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (start) begin
                        f_q      <= POLY;
                        a_q      <= {1'b0, a_in};
                        g1_q     <= '0;
                        g2_q     <= M'(1);
                        launch_q <= 1'b1;
                        state_q  <= ST_DIV;
                    end
                end
                ST_DIV: begin
                    if (div_valid) begin
                        state_q <= (div_rem == '0) ? ST_OUT : ST_STEP;
                    end
                end
                ST_STEP: begin
                    g1_q     <= g2_q;
                    g2_q     <= g2_next;
                    f_q      <= a_q;
                    a_q      <= div_rem;
                    launch_q <= 1'b1;
                    state_q  <= ST_DIV;
                end
                default: begin
                    state_q <= ST_IDLE;
                end
            endcase
        end
    end

    assign done    = (state_q == ST_OUT);
    assign inv_out = g2_q;
endmodule

// File: rtl/gf2m_eea_inverter_chk.sv
// Property checker for the inverter, attached by bind below.
module gf2m_eea_inverter_chk #(
    parameter int M = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  start,
    input logic                  done,
    input logic [M-1:0]          inv_out,
    input gfinv_pkg::inv_state_t state_q,
    input logic [M-1:0]          prod_hi
);
    import gfinv_pkg::*;

    AST_DONE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);  // R3
    AST_HOLD_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_IDLE && !start) |=> $stable(inv_out));  // R5
    AST_OUT_IGNORES_START: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_OUT && start) |=> (state_q == ST_IDLE && !done));  // R4
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STEP) |-> (prod_hi == '0));  // R8
    AST_RESULT_NONZERO: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> (inv_out != '0));  // R2
endmodule

bind gf2m_eea_inverter gf2m_eea_inverter_chk #(.M(M)) u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .done    (done),
    .inv_out (inv_out),
    .state_q (state_q),
    .prod_hi (prod_hi)
);

// File: tb/gf2m_eea_inverter_tb_top.sv
// Bench: exhaustive operand sweep with a behavioural latency/result model.
module gf2m_eea_inverter_tb_top;
    localparam int         M    = 8;
    localparam logic [M:0] POLY = 9'h11B;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         start = 1'b0;
    logic [M-1:0] a_in = '0;
    logic         done;
    logic [M-1:0] inv_out;

    int n_chk = 0;
    int n_bad = 0;
    int n_cyc = 0;

    gf2m_eea_inverter #(.M(M), .POLY(POLY)) dut_i (
        .clk(clk), .rst_n(rst_n), .start(start), .a_in(a_in),
        .done(done), .inv_out(inv_out)
    );

    always #2 clk = ~clk;

    // Watchdog: a hung run is a failure and still prints the summary.
    always @(posedge clk) begin
        n_cyc++;
        if (n_cyc > 200000) begin
            n_bad++;
            $display("FAIL watchdog: cycles %0d expected below 200000", n_cyc);
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    function automatic int deg_of(input int v);
        int d = -1;
        for (int i = 0; i < 32; i++) if (v[i]) d = i;
        return d;
    endfunction

    function automatic int gf_mul(input int x, input int y);
        int p = 0;
        int t = x;
        for (int i = 0; i < M; i++) begin
            if (y[i]) p ^= t;
            t <<= 1;
            if (t[M]) t ^= int'(POLY);
        end
        return p;
    endfunction

    function automatic int gf_inv(input int x);
        for (int b = 1; b < (1 << M); b++) if (gf_mul(x, b) == 1) return b;
        return 0;
    endfunction

    // Edges after the start-sampling edge until done is high (R7).
    function automatic int exp_lat(input int av);
        int f = int'(POLY);
        int d = av;
        int lat = 0;
        for (int rnd = 0; rnd < 2 * M + 2; rnd++) begin
            int r = f;
            int k = 0;
            while (r != 0 && deg_of(r) >= deg_of(d)) begin
                r ^= d << (deg_of(r) - deg_of(d));
                k++;
            end
            if (r == 0) begin
                lat += k + 3;
                break;
            end
            lat += k + 4;
            f = d;
            d = r;
        end
        return lat;
    endfunction

    // One inversion; stray > 0 raises start for one cycle at that cycle.
    task automatic run_vec(input int av, input int stray);
        int lat = exp_lat(av);
        int inv = gf_inv(av);
        @(negedge clk);
        start = 1'b1;
        a_in  = M'(av);
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        for (int cyc = 1; cyc <= lat; cyc++) begin
            @(posedge clk);
            @(negedge clk);
            start = 1'b0;
            chk(done == (cyc == lat), "R7 done timing", int'(done), int'(cyc == lat));
            if (cyc == lat) begin
                chk(gf_mul(av, int'(inv_out)) == 1 && int'(inv_out) == inv,
                    (av == 1) ? "R6 unit operand" : "R2 inverse", int'(inv_out), inv);
            end
            if (cyc == stray) begin
                start = 1'b1;
                a_in  = ~M'(av);
            end
        end
        @(posedge clk);
        @(negedge clk);
        start = 1'b0;
        chk(!done, "R3 single pulse", int'(done), 0);
        chk(int'(inv_out) == inv, "R5 result held", int'(inv_out), inv);
        if (stray > 0) begin
            for (int j = 0; j < 3; j++) begin
                @(posedge clk);
                @(negedge clk);
                chk(!done && int'(inv_out) == inv, "R4 stray start ignored",
                    int'(inv_out), inv);
            end
        end
    endtask

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        chk(!done, "R1 reset done", int'(done), 0);
        chk(inv_out == '0, "R1 reset result", int'(inv_out), 0);
        rst_n = 1'b1;
        repeat (2) @(posedge clk);
        @(negedge clk);
        chk(!done && inv_out == '0, "R1 idle after reset", int'(inv_out), 0);

        run_vec(1, 0);                       // R6
        run_vec(2, 0);
        run_vec(8'h53, 3);                   // R4 start mid-computation
        run_vec(8'h80, exp_lat(8'h80));      // R4 start while done is high
        for (int v = 1; v < (1 << M); v++) run_vec(v, 0);  // R2 R7 sweep

        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end
endmodule